// File: doc/BRIEF.md
# Cascadable Four-Channel Interval Timer Bank

This block holds four independent 16-bit up-counters behind a small register bus. Each channel has a reload value that software writes, a live count that software reads at the same location, and a control halfword. The control halfword picks how many system clocks make up one count step (1, 64, 256 or 1024), whether the channel instead steps on the wrap of the channel below it, whether a wrap raises that channel's interrupt line, and whether the channel runs at all.

A channel loads its reload value into the count only at the moment it is switched on. When a running count passes 0xFFFF it takes the reload value again and keeps going. The wrap can also advance the next channel up in the same clock, so two or more channels form one longer counter. The bus takes halfword and word accesses. Reads are combinational from the current state, and writes take effect at the next rising clock edge.

Top module: `casc_timer_bank`

## Requirements
- R1: After reset, every count, reload value and control halfword is zero, and every `irq` bit is low.
- R2: A halfword write to halfword index 2n sets only channel n's reload value and leaves its count unchanged. A halfword read at index 2n returns channel n's live count.
- R3: A halfword at index 2n+1 is channel n's control. Bits 1:0 select the step rate, bit 2 selects chaining, bit 6 enables the interrupt and bit 7 is run. All other bits are discarded and read back as 0.
- R4: A control write that takes run from 0 to 1 loads the count from the reload value at that edge. A control write while run is already 1 does not reload the count.
- R5: A running channel that is not chained steps once every D clocks, where rate codes 0, 1, 2 and 3 give D = 1, 64, 256 and 1024. The first step lands D edges after the edge that starts the channel.
- R6: When a step finds the count at 0xFFFF, the count takes the reload value at that edge and counting continues from there.
- R7: A wrap on channel n with control bit 6 set drives `irq[n]` high for the single cycle after the wrapping edge. With bit 6 clear, `irq[n]` stays low.
- R8: A running chained channel n > 0 steps exactly on the edges where channel n-1 wraps, and holds its count otherwise. Channel 0 has no lower neighbour, so when chained it never steps.
- R9: A word write to channel n applies its low half as the reload value first and its high half as control second, so a starting word write loads the newly written reload. A word read returns control in bits 31:16 and the count in bits 15:0. Bit 0 of the halfword index is ignored on word accesses.
- R10: A stopped channel (run = 0) holds its count. The write that clears run still lets the old control take its step at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_word | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | HA_W (3) | Halfword index: 2n = channel n reload/count, 2n+1 = channel n control |
| bus_wdata | input | 32 | Write data; halfword writes use bits 15:0 |
| bus_rdata | output | 32 | Combinational read data for the addressed location |
| irq | output | NUM_CH (4) | One-cycle wrap interrupt per channel |

## Verification
A write lands at the first rising edge after it is driven. A read is combinational, so it shows the state left by the most recent edge. A count step and a reload triggered by a wrap both appear right after the edge that causes them. `irq` is registered, so it rises together with the reloaded count and falls one edge later. A chained neighbour steps at the same edge as the wrap below it. The bench drives inputs on falling edges and samples one time unit later. Every expected count is derived by counting edges from the starting write: D edges per step, for example, puts the first step of a /64 channel after edge 64 and never after edge 63.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    localparam int HW_W  = 16;
    localparam int CNT_W = HW_W;
    localparam int PRE_W = 10;

    localparam int CB_RATE_LO = 0;
    localparam int CB_RATE_HI = 1;
    localparam int CB_CHAIN   = 2;
    localparam int CB_IRQ     = 6;
    localparam int CB_RUN     = 7;

    typedef enum logic [1:0] {
        RATE_1    = 2'd0,
        RATE_64   = 2'd1,
        RATE_256  = 2'd2,
        RATE_1024 = 2'd3
    } rate_e;

    typedef struct packed {
        logic  run;
        logic  irq_en;
        logic  chain;
        rate_e rate;
    } ctrl_t;

    typedef struct packed {
        logic            rl_we;
        logic [HW_W-1:0] rl_data;
        logic            ct_we;
        logic [HW_W-1:0] ct_data;
    } chan_wr_t;

    function automatic ctrl_t ctrl_decode(input logic [HW_W-1:0] hw);
        ctrl_t c;
        c.run    = hw[CB_RUN];
        c.irq_en = hw[CB_IRQ];
        c.chain  = hw[CB_CHAIN];
        c.rate   = rate_e'(hw[CB_RATE_HI:CB_RATE_LO]);
        return c;
    endfunction

    function automatic logic [HW_W-1:0] ctrl_encode(input ctrl_t c);
        logic [HW_W-1:0] hw;
        hw = '0;
        hw[CB_RUN]                = c.run;
        hw[CB_IRQ]                = c.irq_en;
        hw[CB_CHAIN]              = c.chain;
        hw[CB_RATE_HI:CB_RATE_LO] = c.rate;
        return hw;
    endfunction

    // Last prescaler value before a step: divisor minus one.
    function automatic logic [PRE_W-1:0] rate_last(input rate_e r);
        logic [PRE_W-1:0] v;
        unique case (r)
            RATE_1:    v = PRE_W'(0);
            RATE_64:   v = PRE_W'(63);
            RATE_256:  v = PRE_W'(255);
            default:   v = PRE_W'(1023);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ctm_prescale.sv
module ctm_prescale
    import ctm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  active,
    input  rate_e rate,
    output logic  tick
);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] last;

    assign last = rate_last(rate);
    // ">=" keeps a mid-run switch to a faster rate from skipping a wrap
    assign tick = active && (div_q >= last);

    always_ff @(posedge clk) begin
        if (rst || clear || !active) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ctm_channel.sv
module ctm_channel
    import ctm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_wr_t         wr,
    input  logic             carry_in,
    output logic [CNT_W-1:0] cnt_o,
    output ctrl_t            ctrl_o,
    output logic             wrap_o
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] start_val;
    logic             start;
    logic             pre_tick;
    logic             step;
    logic             wrap;

    assign ctrl_new  = ctrl_decode(wr.ct_data);
    assign start     = wr.ct_we && !ctrl_q.run && ctrl_new.run;
    // word writes place the reload ahead of control
    assign start_val = wr.rl_we ? wr.rl_data : reload_q;

    ctm_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .active (ctrl_q.run && !ctrl_q.chain),
        .rate   (ctrl_q.rate),
        .tick   (pre_tick)
    );

    assign step = ctrl_q.run && (ctrl_q.chain ? carry_in : pre_tick);
    assign wrap = step && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cnt_q    <= '0;
            reload_q <= '0;
        end else begin
            if (wr.rl_we) begin
                reload_q <= wr.rl_data;
            end
            if (wr.ct_we) begin
                ctrl_q <= ctrl_new;
            end
            if (start) begin
                cnt_q <= start_val;
            end else if (wrap) begin
                cnt_q <= reload_q;
            end else if (step) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign ctrl_o = ctrl_q;
    assign wrap_o = wrap;

endmodule

// File: rtl/ctm_regif.sv
module ctm_regif
    import ctm_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int HA_W   = $clog2(NUM_CH) + 1,
    localparam int CH_W   = HA_W - 1,
    localparam int BUS_W  = 2 * HW_W
) (
    input  logic                         bus_wr,
    input  logic                         bus_word,
    input  logic [HA_W-1:0]              bus_addr,
    input  logic [BUS_W-1:0]             bus_wdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
    input  ctrl_t [NUM_CH-1:0]           ctrl_all,
    output chan_wr_t [NUM_CH-1:0]        wr_all,
    output logic [BUS_W-1:0]             bus_rdata
);

    logic [CH_W-1:0] ch_idx;
    logic            hi_half;

    assign ch_idx  = bus_addr[HA_W-1:1];
    assign hi_half = bus_addr[0];

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            logic sel;
            sel = bus_wr && (ch_idx == CH_W'(i));
            wr_all[i].rl_we   = sel && (bus_word || !hi_half);
            wr_all[i].rl_data = bus_wdata[HW_W-1:0];
            wr_all[i].ct_we   = sel && (bus_word || hi_half);
            wr_all[i].ct_data = bus_word ? bus_wdata[BUS_W-1:HW_W]
                                         : bus_wdata[HW_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_W'(i)) begin
                if (bus_word) begin
                    bus_rdata = {ctrl_encode(ctrl_all[i]), cnt_all[i]};
                end else if (hi_half) begin
                    bus_rdata = {{HW_W{1'b0}}, ctrl_encode(ctrl_all[i])};
                end else begin
                    bus_rdata = {{HW_W{1'b0}}, cnt_all[i]};
                end
            end
        end
    end

endmodule

// File: rtl/casc_timer_bank.sv
module casc_timer_bank
    import ctm_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int HA_W   = $clog2(NUM_CH) + 1,
    localparam int BUS_W  = 2 * HW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [HA_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    chan_wr_t [NUM_CH-1:0]        wr_all;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
    ctrl_t [NUM_CH-1:0]           ctrl_all;
    logic [NUM_CH-1:0]            wrap_all;
    logic [NUM_CH-1:0]            carry_all;
    logic [NUM_CH-1:0]            irq_en_vec;
    logic [NUM_CH-1:0]            irq_q;

    ctm_regif #(.NUM_CH(NUM_CH)) u_regif (
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_all   (cnt_all),
        .ctrl_all  (ctrl_all),
        .wr_all    (wr_all),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i == 0) begin : g_bottom
            assign carry_all[i] = 1'b0;
        end else begin : g_linked
            assign carry_all[i] = wrap_all[i-1];
        end

        assign irq_en_vec[i] = ctrl_all[i].irq_en;

        ctm_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_all[i]),
            .carry_in (carry_all[i]),
            .cnt_o    (cnt_all[i]),
            .ctrl_o   (ctrl_all[i]),
            .wrap_o   (wrap_all[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= wrap_all & irq_en_vec;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/ctm_checker.sv
module ctm_checker
    import ctm_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_CH-1:0]            irq,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
    input ctrl_t [NUM_CH-1:0]           ctrl_all,
    input logic [NUM_CH-1:0]            wrap_all,
    input chan_wr_t [NUM_CH-1:0]        wr_all
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt_all == '0) && (ctrl_all == '0) && (irq == '0)); // R1

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_all[i].run && !wr_all[i].ct_we) |=> $stable(cnt_all[i])); // R10

        AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
            (ctrl_all[i].run && !wr_all[i].ct_we && !wrap_all[i])
            |=> (cnt_all[i] == $past(cnt_all[i]))
             || (cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1))); // R5

        AST_IRQ_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> $past(wrap_all[i]) && $past(ctrl_all[i].irq_en)); // R7

        if (i > 0) begin : g_chain
            AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
                (ctrl_all[i].run && ctrl_all[i].chain && !wr_all[i].ct_we
                 && !wrap_all[i-1]) |=> $stable(cnt_all[i])); // R8
        end else begin : g_base
            AST_BOTTOM_NO_CHAIN: assert property (@(posedge clk) disable iff (rst)
                (ctrl_all[i].chain && !wr_all[i].ct_we) |=> $stable(cnt_all[i])); // R8
        end
    end

endmodule

bind casc_timer_bank ctm_checker #(.NUM_CH(NUM_CH)) u_ctm_checker (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .cnt_all  (cnt_all),
    .ctrl_all (ctrl_all),
    .wrap_all (wrap_all),
    .wr_all   (wr_all)
);

// File: tb/casc_timer_bank_bench.sv
module casc_timer_bank_bench;

    localparam int NUM_CH = 4;
    localparam int HA_W   = 3;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_I = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic        word;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  eirq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    // Channel 0 run at rate 1; each step takes exactly one clock edge.
    localparam vec_t VEC [NV] = '{
        '{OP_W, 1'b0, 3'd0, 32'h0000_FFF0, 32'h0,         4'h0, 4'd2},  // R2 reload only
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_0000, 4'h0, 4'd2},  // R2 count untouched
        '{OP_W, 1'b0, 3'd1, 32'h0000_0080, 32'h0,         4'h0, 4'd4},  // R4 start
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_FFF0, 4'h0, 4'd4},  // R4 loaded
        '{OP_R, 1'b0, 3'd1, 32'h0,         32'h0000_0080, 4'h0, 4'd3},  // R3 readback
        '{OP_R, 1'b1, 3'd0, 32'h0,         32'h0080_FFF2, 4'h0, 4'd9},  // R9 word read
        '{OP_W, 1'b0, 3'd0, 32'h0000_1234, 32'h0,         4'h0, 4'd2},  // R2 reload mid-run
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_FFF4, 4'h0, 4'd2},  // R2 count kept
        '{OP_W, 1'b0, 3'd1, 32'h0000_00C0, 32'h0,         4'h0, 4'd4},  // R4 rewrite, run kept
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_FFF6, 4'h0, 4'd4},  // R4 no reload
        '{OP_I, 1'b0, 3'd0, 32'd8,         32'h0,         4'h0, 4'd5},  // R5 idle
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_FFFF, 4'h0, 4'd6},  // R6 at top
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_1234, 4'h1, 4'd7},  // R6 R7 wrap + irq
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_1235, 4'h0, 4'd7},  // R7 one cycle
        '{OP_W, 1'b0, 3'd1, 32'h0000_0000, 32'h0,         4'h0, 4'd10}, // R10 stop
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_1237, 4'h0, 4'd10}, // R10 last step
        '{OP_R, 1'b1, 3'd0, 32'h0,         32'h0000_1237, 4'h0, 4'd10}, // R10 held
        '{OP_W, 1'b0, 3'd1, 32'h0000_FF38, 32'h0,         4'h0, 4'd3},  // R3 dead bits
        '{OP_R, 1'b0, 3'd1, 32'h0,         32'h0000_0000, 4'h0, 4'd3},  // R3 read as 0
        '{OP_R, 1'b0, 3'd0, 32'h0,         32'h0000_1237, 4'h0, 4'd10}, // R10 still held
        '{OP_R, 1'b1, 3'd1, 32'h0,         32'h0000_1237, 4'h0, 4'd9}   // R9 odd index word
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_word = 1'b0;
    logic [HA_W-1:0]   bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    casc_timer_bank #(.NUM_CH(NUM_CH)) u_casc_timer_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic word, input logic [HA_W-1:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_word  = word;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic word, input logic [HA_W-1:0] a,
                          input logic [31:0] exp, input string req);
        bus_word = word;
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic [3:0] exp, input string req);
        chk(req, {28'h0, irq}, {28'h0, exp});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;

        // R1 reset state
        for (int c = 0; c < NUM_CH; c++) begin
            rd_chk(1'b1, HA_W'(2 * c), 32'h0, "R1");
        end
        irq_chk(4'h0, "R1");

        // vector table, channel 0
        for (int k = 0; k < NV; k++) begin
            case (VEC[k].op)
                OP_W: do_wr(VEC[k].word, VEC[k].addr, VEC[k].data);
                OP_R: begin
                    rd_chk(VEC[k].word, VEC[k].addr, VEC[k].exp,
                           $sformatf("R%0d step %0d", VEC[k].req, k));
                    irq_chk(VEC[k].eirq, $sformatf("R%0d irq step %0d", VEC[k].req, k));
                    step(1);
                end
                default: step(int'(VEC[k].data));
            endcase
        end

        // R5 rate 64 on channel 2: first step after edge 64
        do_wr(1'b0, 3'd4, 32'h0);
        do_wr(1'b0, 3'd5, 32'h0081);
        step(63);
        rd_chk(1'b0, 3'd4, 32'h0000, "R5 /64 edge 63");
        step(1);
        rd_chk(1'b0, 3'd4, 32'h0001, "R5 /64 edge 64");
        step(64);
        rd_chk(1'b0, 3'd4, 32'h0002, "R5 /64 edge 128");

        // R5 rate 256 on channel 3
        do_wr(1'b0, 3'd6, 32'h0010);
        do_wr(1'b0, 3'd7, 32'h0082);
        step(255);
        rd_chk(1'b0, 3'd6, 32'h0010, "R5 /256 edge 255");
        step(1);
        rd_chk(1'b0, 3'd6, 32'h0011, "R5 /256 edge 256");

        // R5 rate 1024 on channel 3
        do_wr(1'b0, 3'd7, 32'h0000);
        do_wr(1'b0, 3'd7, 32'h0083);
        step(1023);
        rd_chk(1'b0, 3'd6, 32'h0010, "R5 /1024 edge 1023");
        step(1);
        rd_chk(1'b0, 3'd6, 32'h0011, "R5 /1024 edge 1024");
        do_wr(1'b0, 3'd5, 32'h0);
        do_wr(1'b0, 3'd7, 32'h0);

        // R9 word write: reload first, then a starting control
        do_wr(1'b1, 3'd2, 32'h0080_ABCD);
        rd_chk(1'b0, 3'd2, 32'h0000_ABCD, "R9 start loads new reload");
        rd_chk(1'b0, 3'd3, 32'h0000_0080, "R9 control half");
        do_wr(1'b0, 3'd3, 32'h0);

        // R8 chain: ch1 (reload FFFF) and ch2 (reload 5) ride on ch0
        do_wr(1'b0, 3'd2, 32'hFFFF);
        do_wr(1'b0, 3'd3, 32'h00C4);
        do_wr(1'b0, 3'd4, 32'h0005);
        do_wr(1'b0, 3'd5, 32'h00C4);
        do_wr(1'b0, 3'd0, 32'hFFFE);
        do_wr(1'b0, 3'd1, 32'h0080);
        rd_chk(1'b0, 3'd0, 32'hFFFE, "R4 ch0 start");
        step(1);
        rd_chk(1'b0, 3'd0, 32'hFFFF, "R5 ch0 top");
        rd_chk(1'b0, 3'd2, 32'hFFFF, "R8 ch1 waits");
        rd_chk(1'b0, 3'd4, 32'h0005, "R8 ch2 waits");
        irq_chk(4'h0, "R7 no wrap yet");
        step(1);
        rd_chk(1'b0, 3'd0, 32'hFFFE, "R6 ch0 wrap");
        rd_chk(1'b0, 3'd2, 32'hFFFF, "R8 ch1 wrap to reload");
        rd_chk(1'b0, 3'd4, 32'h0006, "R8 ch2 same-edge step");
        irq_chk(4'b0010, "R7 ch1 irq only, ch0 disabled");
        step(1);
        rd_chk(1'b0, 3'd4, 32'h0006, "R8 ch2 holds");
        irq_chk(4'h0, "R7 pulse ends");
        step(1);
        rd_chk(1'b0, 3'd4, 32'h0007, "R8 ch2 second step");
        irq_chk(4'b0010, "R7 second ch1 irq");

        // R8 chained channel 0 never steps
        do_wr(1'b0, 3'd1, 32'h0000);
        do_wr(1'b0, 3'd1, 32'h0084);
        step(10);
        rd_chk(1'b0, 3'd0, 32'hFFFE, "R8 ch0 chained frozen");
        rd_chk(1'b0, 3'd4, 32'h0007, "R8 ch2 frozen upstream");

        // R1 reset while running
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            rd_chk(1'b1, HA_W'(2 * c), 32'h0, "R1 after reset");
        end
        irq_chk(4'h0, "R1 irq after reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule